// File: doc/BRIEF.md
# Scoreboard Hazard Tracker for Multi-Unit Issue

This block is the central hazard bookkeeper for a small in-order-issue core that has several functional units. Each instruction arrives with a target unit, one destination register and two source registers. The block accepts the instruction only when the target unit is idle and no unfinished unit already owns the destination. It then tracks the readiness of each source and tells the unit when its operands may be read. After the unit reports completion, the block grants the write-back only when no waiting instruction still needs the old value of the destination.

The block keeps a producer tag for every register, where tag 0 means no pending writer and tag u+1 means unit u. Each unit slot holds its destination, its two source numbers, a ready flag per source and, for a pending source, the tag of the unit that will produce it. When a write-back is granted, every pending source that carries the writer's tag becomes ready, so the result goes straight to the waiting consumers. In the same cycle the destination's tag is cleared and the writer's slot is freed. Only tags and status are modelled; data paths live in the units and the register file.

Top module: `scoreboard_issue_ctl`

## Requirements
- R1: After reset `iss_ready` is high for any unit and register, and `rd_ok` and `wr_grant` are all zero.
- R2: `iss_ready` is low while the unit selected by `iss_fu` (index 0 to NUM_FU-1) holds an instruction. It is high again in the cycle after that unit's write-back grant.
- R3: `iss_ready` is low while the destination register has a producer that has not been granted write-back. It is high again in the cycle after that producer's grant.
- R4: `rd_ok[u]` stays low while either source of unit u waits for a producer.
- R5: A consumer whose last pending source names unit p raises `rd_ok` in the cycle after p's grant.
- R6: When both sources have no producer, `rd_ok[u]` rises in the cycle after the issue. It falls in the cycle after a `rd_take[u]` pulse.
- R7: A finished unit gets no grant while another unit that has not yet taken its operands lists the finished unit's destination as a ready source. The grant comes in the cycle after that reader's `rd_take`, and a blocked unit does not block other eligible units.
- R8: At most one `wr_grant` bit is set per cycle, and when several units are eligible the lowest index wins.
- R9: `wr_grant[u]` (bit u for unit u) rises in the cycle after a `fin_strobe[u]` pulse when no conflict exists. It lasts one cycle, after which the unit is idle.
- R10: An instruction issued in the same cycle its source's producer is granted treats that source as ready, and raises `rd_ok` in the next cycle.
- R11: A `fin_strobe[u]` pulse that arrives before unit u has taken its operands is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| iss_valid | input | 1 | An instruction is offered |
| iss_fu | input | $clog2(NUM_FU) | Index of the target unit |
| iss_dst | input | $clog2(NUM_REGS) | Destination register |
| iss_src_a | input | $clog2(NUM_REGS) | First source register |
| iss_src_b | input | $clog2(NUM_REGS) | Second source register |
| iss_ready | output | 1 | The offered instruction can be accepted (combinational from the offer) |
| rd_ok | output | NUM_FU | Per unit: operands may be read now |
| rd_take | input | NUM_FU | Per unit: operands were read this cycle |
| fin_strobe | input | NUM_FU | Per unit: execution finished, result held |
| wr_grant | output | NUM_FU | Per unit: write back the result this cycle |

## Verification
`iss_ready` and `wr_grant` are combinational from the offered instruction and the registered state. They are therefore due in the same cycle as their stimulus, or one cycle after the pulse or grant that changes that state. `rd_ok` is due one cycle after an issue, an operand take or a producer's grant. The driver tags every expected value with the absolute cycle in which it is due, and the monitor compares only on the falling edge of that cycle. A value that arrives one cycle early or one cycle late is therefore reported as a mismatch.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    FU_IDLE = 2'd0,
    FU_WAIT = 2'd1,
    FU_EXEC = 2'd2,
    FU_DONE = 2'd3
  } fu_state_e;

  localparam int NUM_SRC = 2;

endpackage

// File: rtl/sb_reg_table.sv
module sb_reg_table #(
  parameter int NUM_REGS = 8,
  parameter int RW       = 3,
  parameter int TAGW     = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           set_en,
  input  logic [RW-1:0]                  set_reg,
  input  logic [TAGW-1:0]                set_tag,
  input  logic                           clr_en,
  input  logic [RW-1:0]                  clr_reg,
  output logic [NUM_REGS-1:0][TAGW-1:0]  tag_q
);

  logic [NUM_REGS-1:0][TAGW-1:0] tag_nxt;
  logic                          tbl_en;

  assign tbl_en = set_en | clr_en;

  always_comb begin
    tag_nxt = tag_q;
    if (clr_en) tag_nxt[clr_reg] = '0;
    if (set_en) tag_nxt[set_reg] = set_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tag_q <= '0;
    else if (tbl_en) tag_q <= tag_nxt;
  end

  // R3
  no_waw_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (tag_q[set_reg] == '0));

endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
  import sb_pkg::*;
#(
  parameter int RW   = 3,
  parameter int TAGW = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [RW-1:0]                 ld_dst,
  input  logic [NUM_SRC-1:0][RW-1:0]    ld_src,
  input  logic [NUM_SRC-1:0][TAGW-1:0]  ld_tag,
  input  logic [TAGW-1:0]               wb_tag,
  input  logic                          take,
  input  logic                          fin,
  input  logic                          grant,
  output fu_state_e                     state_q,
  output logic [RW-1:0]                 dst_q,
  output logic [NUM_SRC-1:0][RW-1:0]    src_q,
  output logic [NUM_SRC-1:0]            vld_q,
  output logic                          rd_ok
);

  fu_state_e                     state_nxt;
  logic [RW-1:0]                 dst_nxt;
  logic [NUM_SRC-1:0][RW-1:0]    src_nxt;
  logic [NUM_SRC-1:0][TAGW-1:0]  tag_q, tag_nxt;
  logic [NUM_SRC-1:0]            vld_nxt;
  logic [NUM_SRC-1:0]            fwd_hit;
  logic                          slot_en;

  assign rd_ok = (state_q == FU_WAIT) && (&vld_q);

  for (genvar j = 0; j < NUM_SRC; j++) begin : g_fwd
    assign fwd_hit[j] = !vld_q[j] && (wb_tag != '0) && (tag_q[j] == wb_tag);
  end

  always_comb begin
    state_nxt = state_q;
    dst_nxt   = dst_q;
    src_nxt   = src_q;
    tag_nxt   = tag_q;
    vld_nxt   = vld_q;
    unique case (state_q)
      FU_IDLE: if (load) begin
        state_nxt = FU_WAIT;
        dst_nxt   = ld_dst;
        src_nxt   = ld_src;
        tag_nxt   = ld_tag;
        for (int j = 0; j < NUM_SRC; j++) vld_nxt[j] = (ld_tag[j] == '0);
      end
      FU_WAIT: begin
        vld_nxt = vld_q | fwd_hit;
        if (rd_ok && take) state_nxt = FU_EXEC;
      end
      FU_EXEC: if (fin)   state_nxt = FU_DONE;
      FU_DONE: if (grant) state_nxt = FU_IDLE;
      default:            state_nxt = FU_IDLE;
    endcase
  end

  assign slot_en = (state_nxt != state_q) || (|fwd_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FU_IDLE;
      dst_q   <= '0;
      src_q   <= '0;
      tag_q   <= '0;
      vld_q   <= '0;
    end else if (slot_en) begin
      state_q <= state_nxt;
      dst_q   <= dst_nxt;
      src_q   <= src_nxt;
      tag_q   <= tag_nxt;
      vld_q   <= vld_nxt;
    end
  end

  // R2
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (state_q == FU_IDLE));

  // R9
  grant_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (state_q == FU_DONE));

  // R9
  grant_frees_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (state_q == FU_IDLE));

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter
  import sb_pkg::*;
#(
  parameter int NUM_FU = 4,
  parameter int RW     = 3,
  parameter int TAGW   = 3
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [NUM_FU-1:0]                        done_v,
  input  logic [NUM_FU-1:0]                        wait_v,
  input  logic [NUM_FU-1:0][RW-1:0]                dst_v,
  input  logic [NUM_FU-1:0][NUM_SRC-1:0][RW-1:0]   src_v,
  input  logic [NUM_FU-1:0][NUM_SRC-1:0]           vld_v,
  output logic [NUM_FU-1:0]                        grant,
  output logic [TAGW-1:0]                          wb_tag,
  output logic [RW-1:0]                            wb_dst
);

  logic [NUM_FU-1:0] war_hit;
  logic [NUM_FU-1:0] elig;
  logic              taken;

  always_comb begin
    war_hit = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      for (int v = 0; v < NUM_FU; v++) begin
        for (int j = 0; j < NUM_SRC; j++) begin
          if ((u != v) && wait_v[v] && vld_v[v][j] && (src_v[v][j] == dst_v[u]))
            war_hit[u] = 1'b1;
        end
      end
    end
  end

  assign elig = done_v & ~war_hit;

  always_comb begin
    grant  = '0;
    taken  = 1'b0;
    wb_tag = '0;
    wb_dst = '0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (elig[u] && !taken) begin
        grant[u] = 1'b1;
        taken    = 1'b1;
        wb_tag   = TAGW'(u) + TAGW'(1);
        wb_dst   = dst_v[u];
      end
    end
  end

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

endmodule

// File: rtl/scoreboard_issue_ctl.sv
module scoreboard_issue_ctl
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         iss_valid,
  input  logic [$clog2(NUM_FU)-1:0]    iss_fu,
  input  logic [$clog2(NUM_REGS)-1:0]  iss_dst,
  input  logic [$clog2(NUM_REGS)-1:0]  iss_src_a,
  input  logic [$clog2(NUM_REGS)-1:0]  iss_src_b,
  output logic                         iss_ready,
  output logic [NUM_FU-1:0]            rd_ok,
  input  logic [NUM_FU-1:0]            rd_take,
  input  logic [NUM_FU-1:0]            fin_strobe,
  output logic [NUM_FU-1:0]            wr_grant
);

  localparam int FUW  = $clog2(NUM_FU);
  localparam int RW   = $clog2(NUM_REGS);
  localparam int TAGW = $clog2(NUM_FU + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fu_state_e                               fu_state [NUM_FU];
  logic [NUM_FU-1:0]                       done_v, wait_v;
  logic [NUM_FU-1:0][RW-1:0]               dst_v;
  logic [NUM_FU-1:0][NUM_SRC-1:0][RW-1:0]  src_v;
  logic [NUM_FU-1:0][NUM_SRC-1:0]          vld_v;
  logic [NUM_REGS-1:0][TAGW-1:0]           reg_tag;
  logic [TAGW-1:0]                         wb_tag;
  logic [RW-1:0]                           wb_dst;
  logic                                    wb_any;
  logic                                    iss_fire;
  logic [NUM_SRC-1:0][RW-1:0]              iss_src;
  logic [NUM_SRC-1:0][TAGW-1:0]            iss_tag;

  assign iss_src   = {iss_src_b, iss_src_a};
  assign iss_ready = (fu_state[iss_fu] == FU_IDLE) && (reg_tag[iss_dst] == '0);
  assign iss_fire  = iss_valid && iss_ready;
  assign wb_any    = (wb_tag != '0);

  // a source whose producer writes back this cycle is captured as ready
  for (genvar j = 0; j < NUM_SRC; j++) begin : g_src_tag
    assign iss_tag[j] = (wb_any && (reg_tag[iss_src[j]] == wb_tag)) ? '0
                                                                    : reg_tag[iss_src[j]];
  end

  sb_reg_table #(
    .NUM_REGS (NUM_REGS),
    .RW       (RW),
    .TAGW     (TAGW)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (iss_fire),
    .set_reg (iss_dst),
    .set_tag (TAGW'(iss_fu) + TAGW'(1)),
    .clr_en  (wb_any),
    .clr_reg (wb_dst),
    .tag_q   (reg_tag)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_slot
    logic load_u;
    assign load_u = iss_fire && (iss_fu == FUW'(u));

    sb_fu_slot #(
      .RW   (RW),
      .TAGW (TAGW)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .load    (load_u),
      .ld_dst  (iss_dst),
      .ld_src  (iss_src),
      .ld_tag  (iss_tag),
      .wb_tag  (wb_tag),
      .take    (rd_take[u]),
      .fin     (fin_strobe[u]),
      .grant   (wr_grant[u]),
      .state_q (fu_state[u]),
      .dst_q   (dst_v[u]),
      .src_q   (src_v[u]),
      .vld_q   (vld_v[u]),
      .rd_ok   (rd_ok[u])
    );

    assign done_v[u] = (fu_state[u] == FU_DONE);
    assign wait_v[u] = (fu_state[u] == FU_WAIT);
  end

  sb_wb_arbiter #(
    .NUM_FU (NUM_FU),
    .RW     (RW),
    .TAGW   (TAGW)
  ) u_arb (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .done_v (done_v),
    .wait_v (wait_v),
    .dst_v  (dst_v),
    .src_v  (src_v),
    .vld_v  (vld_v),
    .grant  (wr_grant),
    .wb_tag (wb_tag),
    .wb_dst (wb_dst)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_war_chk
    for (genvar v = 0; v < NUM_FU; v++) begin : g_rd
      if (u != v) begin : g_pair
        // R7
        war_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
          (wait_v[v] && vld_v[v][0] && (src_v[v][0] == dst_v[u])) |-> !wr_grant[u]);
        // R7
        war_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
          (wait_v[v] && vld_v[v][1] && (src_v[v][1] == dst_v[u])) |-> !wr_grant[u]);
      end
    end
  end

endmodule

// File: tb/scoreboard_issue_ctl_test.sv
module scoreboard_issue_ctl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iss_valid = 1'b0;
  logic [1:0] iss_fu = '0;
  logic [2:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic       iss_ready;
  logic [3:0] rd_ok, wr_grant;
  logic [3:0] rd_take = '0, fin_strobe = '0;

  always #2 clk = ~clk;

  scoreboard_issue_ctl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_fu     (iss_fu),
    .iss_dst    (iss_dst),
    .iss_src_a  (iss_src_a),
    .iss_src_b  (iss_src_b),
    .iss_ready  (iss_ready),
    .rd_ok      (rd_ok),
    .rd_take    (rd_take),
    .fin_strobe (fin_strobe),
    .wr_grant   (wr_grant)
  );

  typedef struct {
    int         cyc;
    int         kind;   // 0 ready, 1 rd_ok, 2 wr_grant
    logic [3:0] val;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   ended = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare expectations due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        logic [3:0] act;
        act = (q[i].kind == 0) ? {3'b000, iss_ready} :
              (q[i].kind == 1) ? rd_ok : wr_grant;
        checks++;
        if (act !== q[i].val) begin
          fails++;
          $display("FAIL %s cycle %0d kind %0d actual=%b expected=%b",
                   q[i].req, cyc, q[i].kind, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    iss_valid  = 1'b0;
    rd_take    = '0;
    fin_strobe = '0;
  endtask

  task automatic push(int kind, logic [3:0] val, string req);
    exp_t e;
    e.cyc = cyc; e.kind = kind; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic issue(int fu, int d, int a, int b);
    iss_valid = 1'b1;
    iss_fu    = 2'(fu);
    iss_dst   = 3'(d);
    iss_src_a = 3'(a);
    iss_src_b = 3'(b);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // reset state
    iss_fu = 2'd0; iss_dst = 3'd1;
    push(0, 4'b0001, "R1"); push(1, 4'b0000, "R1"); push(2, 4'b0000, "R1");

    // dependency chain with RAW, WAW and WAR
    tick(); issue(0, 1, 2, 3); push(0, 4'b0001, "R2");
    tick(); push(1, 4'b0001, "R6"); rd_take[0] = 1'b1;
    tick(); push(1, 4'b0000, "R6"); issue(1, 4, 1, 5); push(0, 4'b0001, "R3");
    tick(); push(1, 4'b0000, "R4"); issue(2, 1, 7, 7); push(0, 4'b0000, "R3");
    tick(); issue(0, 6, 7, 7); push(0, 4'b0000, "R2"); fin_strobe[0] = 1'b1;
    tick(); push(2, 4'b0001, "R9"); push(1, 4'b0000, "R4");
            issue(2, 1, 7, 7); push(0, 4'b0000, "R3");
    tick(); push(2, 4'b0000, "R9"); push(1, 4'b0010, "R5");
            issue(2, 1, 7, 7); push(0, 4'b0001, "R3");
    tick(); push(1, 4'b0110, "R6"); rd_take[2] = 1'b1;
            issue(0, 2, 3, 3); push(0, 4'b0001, "R2");
    tick(); push(1, 4'b0011, "R6"); rd_take[0] = 1'b1; fin_strobe[2] = 1'b1;
    tick(); push(1, 4'b0010, "R7"); push(2, 4'b0000, "R7"); fin_strobe[0] = 1'b1;
    tick(); push(2, 4'b0001, "R7"); rd_take[1] = 1'b1;
    tick(); push(2, 4'b0100, "R7"); push(1, 4'b0000, "R7");
    tick(); push(2, 4'b0000, "R8"); fin_strobe[1] = 1'b1;
    tick(); push(2, 4'b0010, "R9");
    tick(); push(2, 4'b0000, "R9");

    // simultaneous completions: lowest index first
    tick(); issue(3, 5, 0, 0); push(0, 4'b0001, "R8");
    tick(); push(1, 4'b1000, "R6"); rd_take[3] = 1'b1;
            issue(1, 6, 0, 0); push(0, 4'b0001, "R8");
    tick(); push(1, 4'b0010, "R6"); rd_take[1] = 1'b1;
    tick(); push(1, 4'b0000, "R6"); fin_strobe[1] = 1'b1; fin_strobe[3] = 1'b1;
    tick(); push(2, 4'b0010, "R8");
    tick(); push(2, 4'b1000, "R8");
    tick(); push(2, 4'b0000, "R8");

    // issue in the same cycle as the producer's write-back
    tick(); issue(0, 3, 0, 0);
    tick(); push(1, 4'b0001, "R6"); rd_take[0] = 1'b1;
    tick(); fin_strobe[0] = 1'b1;
    tick(); push(2, 4'b0001, "R10"); issue(1, 4, 3, 3); push(0, 4'b0001, "R10");
    tick(); push(1, 4'b0010, "R10"); push(2, 4'b0000, "R10"); rd_take[1] = 1'b1;
    tick(); fin_strobe[1] = 1'b1;
    tick(); push(2, 4'b0010, "R9");

    // early completion strobe is ignored
    tick(); issue(2, 0, 0, 0);
    tick(); push(1, 4'b0100, "R11"); fin_strobe[2] = 1'b1;
    tick(); push(2, 4'b0000, "R11"); push(1, 4'b0100, "R11"); rd_take[2] = 1'b1;
    tick(); push(2, 4'b0000, "R11"); fin_strobe[2] = 1'b1;
    tick(); push(2, 4'b0100, "R11");
    tick(); push(2, 4'b0000, "R11");

    tick(); tick();
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1 pending expectations actual=%0d expected=0", q.size());
    end
    finish_run();
  end

endmodule